// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers a set of event sources into a single active-low interrupt line for a host processor. It keeps two registers: a flag register, which the host reads to see what happened, and an enable register, which selects which flags may drive the interrupt. The two kinds of flag behave differently. Event flags, such as a power-loss notice, latch on the rising edge of their input and stay set until the host writes 1 to that bit. Alert flags follow the live level of an active-low alert pin and cannot be cleared by a write. A host can only quiet an alert by clearing its enable bit.

A simple register port gives access. When select and write are both high in a cycle, the write takes effect at the next rising clock edge. A read returns data from the same cycle as the select. The flag register sits at offset 0x0 and the enable register at offset 0x4. The interrupt line is driven by a two-state machine. In `IRQ_IDLE` the line is high (inactive). The machine goes from `IRQ_IDLE` to `IRQ_RAISED` on the first edge where some enabled flag is set. In `IRQ_RAISED` the line is low. The machine goes back from `IRQ_RAISED` to `IRQ_IDLE` on the first edge where no enabled flag remains. A host handler can therefore read the flags, clear what it saw and read again until the line goes high, and no late event is lost.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the flag register and the enable register both read 0 and `irq_n` is 1.
- R2: Event input i passes through two synchronizer flops and an edge detector. A 0-to-1 transition sets flag bit i, which is bits [N_EVT-1:0] of offset 0x0. The bit stays set after the input falls. A level held high does not set the bit again once it has been cleared.
- R3: A write to offset 0x0 clears each event flag whose data bit is 1 and leaves each event flag whose data bit is 0 unchanged. This holds for every event bit, the power-loss event on bit 0 included.
- R4: When an event edge and a write of 1 to the same flag bit land on the same clock edge, the flag ends up set.
- R5: Alert flag j, at bit N_EVT+j of offset 0x0, reads as the inverse of `alert_n[j]` sampled two clock edges earlier. A write of 1 to that bit has no effect.
- R6: `irq_n` is 0 exactly when, at the previous clock edge, the bitwise AND of the flag and enable registers was nonzero. Each enable bit sits at the same position as its flag bit.
- R7: If a new event flag is set while `irq_n` is low, and the host clears only the flags it had read before, `irq_n` stays low until the new flag is cleared too.
- R8: Clearing the enable bit of an active alert makes `irq_n` go high one edge later while the flag still reads 1. Setting the enable bit again with the alert still active drives `irq_n` low one edge after the write.
- R9: A write to offset 0x4 loads data bits [N_EVT+N_ALERT-1:0] into the enable register. The bits above read back as 0. At any other offset, writes change nothing and reads return 0.
- R10: The interrupt machine moves from IRQ_IDLE to IRQ_RAISED when some enabled flag is set, and from IRQ_RAISED to IRQ_IDLE when none is. The line is low only in IRQ_RAISED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of the select |
| evt_in | input | N_EVT | Raw event inputs, active high, asynchronous |
| alert_n | input | N_ALERT | Alert pins, active low, asynchronous |
| irq_n | output | 1 | Interrupt request to the host, active low |

## Verification
The bound checker watches a fixed set of relations on every cycle:
- the interrupt line agrees with the enabled flags of the previous edge;
- an event flag never drops unless the previous edge carried a write of 1 to it, and it always drops when it did, unless an edge arrived on that same edge;
- a fresh edge always leaves its flag set;
- the alert bits mirror the pins with two edges of delay;
- an enable write loads exactly the written bits.

Some behaviour only shows up as a sequence of scenarios, so the bench covers it. That includes a held event not coming back after a clear, and a late event outliving a clear of the older flags. It also includes a masked alert that still reads as set and fires at once when re-enabled, and decode of unused offsets. The bench also sweeps every enable mask against two fixed flag patterns, and sweeps all event patterns against partial clears.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned FLAG_OFS = 0;
    localparam int unsigned EN_OFS   = 4;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int unsigned W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= {W{RST_VAL}};
            stage2_q <= {W{RST_VAL}};
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs #(
    parameter int unsigned N_EVT   = 4,
    parameter int unsigned N_ALERT = 2,
    parameter int unsigned DW      = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_flags,
    input  logic                       wr_enables,
    input  logic                       rd_flags,
    input  logic                       rd_enables,
    input  logic [DW-1:0]              wdata,
    input  logic [N_EVT-1:0]           evt_rise,
    input  logic [N_ALERT-1:0]         alert_act,
    output logic [DW-1:0]              rdata,
    output logic [N_EVT+N_ALERT-1:0]   flags,
    output logic [N_EVT+N_ALERT-1:0]   enables
);
    localparam int unsigned NF = N_EVT + N_ALERT;

    logic [N_EVT-1:0] evt_q;
    logic [N_EVT-1:0] evt_nxt;
    logic [NF-1:0]    en_q;
    logic             unused_wdata;

    assign unused_wdata = ^wdata[DW-1:NF];

    // Set has priority over the write-1-to-clear for every event bit.
    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        always_comb begin
            if (evt_rise[i])
                evt_nxt[i] = 1'b1;
            else if (wr_flags && wdata[i])
                evt_nxt[i] = 1'b0;
            else
                evt_nxt[i] = evt_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
            en_q  <= '0;
        end else begin
            evt_q <= evt_nxt;
            if (wr_enables)
                en_q <= wdata[NF-1:0];
        end
    end

    assign flags   = {alert_act, evt_q};
    assign enables = en_q;

    always_comb begin
        if (rd_flags)
            rdata = DW'(flags);
        else if (rd_enables)
            rdata = DW'(en_q);
        else
            rdata = '0;
    end
endmodule

// File: rtl/irqagg_irq_fsm.sv
module irqagg_irq_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_n
);
    irq_state_e state_q;
    irq_state_e state_nxt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_nxt = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_nxt = IRQ_IDLE;
            default:    state_nxt = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_IDLE;
        else
            state_q <= state_nxt;
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned N_EVT   = 4,
    parameter int unsigned N_ALERT = 2,
    parameter int unsigned AW      = 4,
    parameter int unsigned DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [N_EVT-1:0]   evt_in,
    input  logic [N_ALERT-1:0] alert_n,
    output logic               irq_n
);
    localparam int unsigned NF = N_EVT + N_ALERT;

    logic [N_EVT-1:0]   evt_sync;
    logic [N_EVT-1:0]   evt_prev_q;
    logic [N_EVT-1:0]   evt_rise;
    logic [N_ALERT-1:0] alert_sync_n;
    logic [NF-1:0]      flags;
    logic [NF-1:0]      enables;
    logic               hit_flags;
    logic               hit_enables;
    logic               pending;

    irqagg_sync #(.W(N_EVT), .RST_VAL(1'b0)) u_evt_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (evt_in),
        .q_sync  (evt_sync)
    );

    irqagg_sync #(.W(N_ALERT), .RST_VAL(1'b1)) u_alert_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (alert_n),
        .q_sync  (alert_sync_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            evt_prev_q <= '0;
        else
            evt_prev_q <= evt_sync;
    end

    assign evt_rise    = evt_sync & ~evt_prev_q;
    assign hit_flags   = bus_sel && (bus_addr == AW'(FLAG_OFS));
    assign hit_enables = bus_sel && (bus_addr == AW'(EN_OFS));

    irqagg_regs #(.N_EVT(N_EVT), .N_ALERT(N_ALERT), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_flags   (hit_flags && bus_wr),
        .wr_enables (hit_enables && bus_wr),
        .rd_flags   (hit_flags && !bus_wr),
        .rd_enables (hit_enables && !bus_wr),
        .wdata      (bus_wdata),
        .evt_rise   (evt_rise),
        .alert_act  (~alert_sync_n),
        .rdata      (bus_rdata),
        .flags      (flags),
        .enables    (enables)
    );

    assign pending = |(flags & enables);

    irqagg_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irqagg_pkg::*;
#(
    parameter int unsigned N_EVT   = 4,
    parameter int unsigned N_ALERT = 2,
    parameter int unsigned AW      = 4,
    parameter int unsigned DW      = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [AW-1:0]            bus_addr,
    input logic [DW-1:0]            bus_wdata,
    input logic [N_ALERT-1:0]       alert_n,
    input logic [N_EVT-1:0]         evt_rise,
    input logic [N_EVT+N_ALERT-1:0] flags,
    input logic [N_EVT+N_ALERT-1:0] enables,
    input logic                     irq_n
);
    localparam int unsigned NF = N_EVT + N_ALERT;

    logic [N_EVT-1:0] clr_req;
    logic [N_EVT-1:0] evt_f;
    logic             en_write;

    assign evt_f    = flags[N_EVT-1:0];
    assign clr_req  = (bus_sel && bus_wr && bus_addr == AW'(FLAG_OFS)) ? bus_wdata[N_EVT-1:0] : '0;
    assign en_write = bus_sel && bus_wr && (bus_addr == AW'(EN_OFS));

    // R6 / R10: line follows the enabled flags of the previous edge
    a_r6_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|($past(flags & enables))));

    // R3: an event flag only drops after a write of 1 to it
    a_r3_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(evt_f) & ~$past(clr_req)) & ~evt_f) == '0));

    // R3: a write of 1 without a coincident edge really clears
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(clr_req) & ~$past(evt_rise)) & evt_f) == '0));

    // R4: an edge always leaves its flag set
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_rise) & ~evt_f) == '0));

    // R5: alert bits mirror the pins two edges late
    a_r5_alert_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        flags[NF-1:N_EVT] == ~$past(alert_n, 2));

    // R9: enable write loads the written bits
    a_r9_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        en_write |=> enables == $past(bus_wdata[NF-1:0]));
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .N_EVT(N_EVT), .N_ALERT(N_ALERT), .AW(AW), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .alert_n   (alert_n),
    .evt_rise  (evt_rise),
    .flags     (flags),
    .enables   (enables),
    .irq_n     (irq_n)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
    localparam int unsigned N_EVT   = 4;
    localparam int unsigned N_ALERT = 2;
    localparam int unsigned AW      = 4;
    localparam int unsigned DW      = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [AW-1:0]      bus_addr = '0;
    logic [DW-1:0]      bus_wdata = '0;
    logic [DW-1:0]      bus_rdata;
    logic [N_EVT-1:0]   evt_in = '0;
    logic [N_ALERT-1:0] alert_n = '1;
    logic               irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator #(.N_EVT(N_EVT), .N_ALERT(N_ALERT), .AW(AW), .DW(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt_in),
        .alert_n   (alert_n),
        .irq_n     (irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [N_EVT-1:0] m);
        @(negedge clk);
        evt_in = evt_in | m;
        idle(3);
        evt_in = evt_in & ~m;
        idle(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] seen;

        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        idle(3);
        rd(4'h0, d); check("R1 flags after reset", d, 32'h0);
        rd(4'h4, d); check("R1 enables after reset", d, 32'h0);
        check("R1 irq_n after reset", {31'h0, irq_n}, 32'h1);

        // R2: edge latch, persistence, no relatch from held level
        pulse(4'h1);
        rd(4'h0, d); check("R2 power-loss flag latched", d, 32'h1);
        check("R6 disabled flag keeps irq_n high", {31'h0, irq_n}, 32'h1);
        @(negedge clk); evt_in[1] = 1'b1;
        idle(4);
        rd(4'h0, d); check("R2 second event latched", d, 32'h3);
        wr(4'h0, 32'h2);
        idle(3);
        rd(4'h0, d); check("R2 held level does not relatch", d, 32'h1);
        evt_in[1] = 1'b0;

        // R3: write 0 keeps, write 1 clears (power-loss bit)
        wr(4'h0, 32'h0);
        rd(4'h0, d); check("R3 write zero keeps flag", d, 32'h1);
        wr(4'h0, 32'h1);
        rd(4'h0, d); check("R3 power-loss flag clears", d, 32'h0);

        // R3: sweep all event patterns with a partial clear
        for (int p = 1; p < 16; p++) begin
            pulse(4'(p));
            rd(4'h0, d); check("R2 pattern latched", d, 32'(p));
            wr(4'h0, 32'h5);
            rd(4'h0, d); check("R3 partial clear", d, 32'(p & 32'hA));
            wr(4'h0, 32'hF);
            rd(4'h0, d); check("R3 full clear", d, 32'h0);
        end

        // R4: edge and clear on the same clock edge
        pulse(4'h4);
        @(negedge clk); evt_in[2] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h4;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        evt_in[2] = 1'b0;
        idle(3);
        rd(4'h0, d); check("R4 set wins over clear", d, 32'h4);
        wr(4'h0, 32'hF);

        // R5: alerts mirror pins, not clearable
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); alert_n = ~2'(a);
            idle(3);
            rd(4'h0, d); check("R5 alert mirror", d, 32'(a << N_EVT));
            wr(4'h0, 32'h30);
            rd(4'h0, d); check("R5 alert write-1 ignored", d, 32'(a << N_EVT));
        end

        // R6: sweep all enable masks against two flag patterns
        pulse(4'hF);
        @(negedge clk); alert_n = 2'b00;
        idle(3);
        for (int e = 0; e < 64; e++) begin
            wr(4'h4, 32'(e));
            idle(1);
            check("R6 all flags set", {31'h0, irq_n}, {31'h0, (e == 0)});
        end
        wr(4'h0, 32'hA);
        @(negedge clk); alert_n = 2'b01;
        idle(3);
        for (int e = 0; e < 64; e++) begin
            wr(4'h4, 32'(e));
            idle(1);
            check("R6 flags 0x25", {31'h0, irq_n}, {31'h0, ((e & 32'h25) == 0)});
        end
        wr(4'h4, 32'h0);
        wr(4'h0, 32'hF);
        @(negedge clk); alert_n = 2'b11;
        idle(3);

        // R7: late event survives clear of earlier flags
        wr(4'h4, 32'hF);
        pulse(4'h1);
        check("R10 raised on enabled flag", {31'h0, irq_n}, 32'h0);
        rd(4'h0, seen);
        pulse(4'h2);
        wr(4'h0, seen);
        idle(1);
        check("R7 irq_n held by late event", {31'h0, irq_n}, 32'h0);
        rd(4'h0, d); check("R7 late flag still set", d, 32'h2);
        wr(4'h0, d);
        idle(1);
        check("R10 idle when nothing pending", {31'h0, irq_n}, 32'h1);

        // R8: mask and re-enable an active alert
        wr(4'h4, 32'h10);
        @(negedge clk); alert_n = 2'b10;
        idle(3);
        check("R8 alert raises irq", {31'h0, irq_n}, 32'h0);
        wr(4'h4, 32'h0);
        idle(1);
        check("R8 masked alert releases irq", {31'h0, irq_n}, 32'h1);
        rd(4'h0, d); check("R8 masked alert still reads set", d, 32'h10);
        wr(4'h4, 32'h10);
        idle(1);
        check("R8 re-enable reasserts irq", {31'h0, irq_n}, 32'h0);
        @(negedge clk); alert_n = 2'b11;
        idle(4);
        check("R8 alert gone releases irq", {31'h0, irq_n}, 32'h1);

        // R9: enable width and decode
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); check("R9 enable upper bits zero", d, 32'h3F);
        wr(4'h8, 32'h0);
        rd(4'h4, d); check("R9 other offset write ignored", d, 32'h3F);
        rd(4'h8, d); check("R9 other offset reads zero", d, 32'h0);
        wr(4'h4, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule